// File: doc/BRIEF.md
# CAN Node Status and Control Word

This block is the 16-bit status and control word of a CAN controller, seen by the CPU as a high and a low byte on a simple register bus. It shows live frame activity (transmitting, message on the bus) and the two-bit error state of the node. It keeps a sticky flag that records when the error state steps up, or when the node comes back from bus-off to error-active. An interrupt is raised while that flag and its enable are both set. The low byte holds three control bits: halt bus operation, transmit output enable and the interrupt enable.

The node state comes from external error-counter logic. The activity inputs come from the protocol engine. Both are sampled on every clock. The registered value of the node state is the one shown to the CPU, and it is also the reference for detecting transitions.

The design uses three state machines. The node tracker has the states ERR_ACTIVE, ERR_WARNING, ERR_PASSIVE and ERR_BUSOFF. Its qualifying transitions are ACTIVE→WARNING, WARNING→PASSIVE, PASSIVE→BUSOFF and BUSOFF→ACTIVE. The flag machine has the states FLAG_CLEAR and FLAG_RAISED: it goes CLEAR→RAISED on a qualifying transition and RAISED→CLEAR on a write of zero. The activity machine has the states ACT_IDLE, ACT_RX and ACT_TX and moves between them on the sampled activity inputs.

Top module: `can_status_csr`

## Requirements
- R1: After reset the read word is 16'h0001 (only halt set) and irq_o is 0. Bits 13:11, 6:3 and 1 always read 0.
- R2: Bit 15 (transmitting) reads 1 one clock after a cycle in which tx_msg_i=1, fault_frame_i=0 and halt was 0. Otherwise it reads 0.
- R3: Bit 14 (message on bus) reads 1 one clock after a cycle in which tx_msg_i or bus_msg_i was 1, fault_frame_i=0 and halt was 0. Otherwise it reads 0.
- R4: Bits 9:8 show node_state_i as sampled at the previous clock, using the encoding 00 error active, 01 warning, 10 error passive, 11 bus off.
- R5: Bit 10 (transition flag) becomes 1 one clock after the input state differs from bits 9:8 by one of these steps: 00→01, 01→10, 10→11 or 11→00.
- R6: Any other change of node state, including a skipped level or a step down, leaves bit 10 unchanged.
- R7: A write with bus_be_i[1]=1 and data bit 10 = 0 clears bit 10. A write of 1 to bit 10 has no effect.
- R8: If a qualifying transition and a clearing write occur in the same clock, bit 10 ends at 1.
- R9: irq_o is 1 exactly while bit 10 and bit 2 (interrupt enable) both read 1.
- R10: A write with bus_be_i[0]=1 loads bit 7 (output enable), bit 2 (interrupt enable) and bit 0 (halt) from the data. Reset values are 0, 0 and 1.
- R11: Writes to bits 15:14 and 9:8 have no effect, and a write with both byte enables at 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one clock per write |
| bus_be_i | input | 2 | Byte enables: [1] bits 15:8, [0] bits 7:0 |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Current register word |
| node_state_i | input | 2 | Node error state from the error counters |
| tx_msg_i | input | 1 | Engine is sending a data or remote frame |
| bus_msg_i | input | 1 | A message is on the bus |
| fault_frame_i | input | 1 | An error or overload frame is on the bus |
| irq_o | output | 1 | Transition interrupt |

## Verification
The node-state input is driven through all four qualifying steps. It is also driven through skipped levels (00→10, 01→11) and downward steps (01→00, 11→10). This separates a design that flags only the listed escalations from one that flags any change. Clearing writes are placed alone, together with a qualifying step (set must win), and behind a zero byte enable, to show the priority and the lane gating. The activity inputs are tried as transmit, receive-only, with a fault frame present, and with halt set, so each gating term is shown to matter on its own.

// File: rtl/can_csr_pkg.sv
package can_csr_pkg;

    localparam int CSR_W  = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = CSR_W / LANE_W;

    // bit positions the CPU software decodes
    localparam int POS_TX   = 15;
    localparam int POS_RX   = 14;
    localparam int POS_FLAG = 10;
    localparam int POS_NS_H = 9;
    localparam int POS_NS_L = 8;
    localparam int POS_OE   = 7;
    localparam int POS_IE   = 2;
    localparam int POS_HALT = 0;

    typedef enum logic [1:0] {
        ERR_ACTIVE  = 2'b00,
        ERR_WARNING = 2'b01,
        ERR_PASSIVE = 2'b10,
        ERR_BUSOFF  = 2'b11
    } node_e;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'b00,
        ACT_RX   = 2'b01,
        ACT_TX   = 2'b10
    } act_e;

endpackage

// File: rtl/can_csr_node_fsm.sv
module can_csr_node_fsm
    import can_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  node_e node_in,
    output node_e node_q,
    output logic  step_o
);

    node_e state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_ACTIVE;
        else        state_q <= node_in;
    end

    // qualifying transitions, judged from the registered state
    always_comb begin
        step_o = 1'b0;
        unique case (state_q)
            ERR_ACTIVE:  step_o = (node_in == ERR_WARNING);
            ERR_WARNING: step_o = (node_in == ERR_PASSIVE);
            ERR_PASSIVE: step_o = (node_in == ERR_BUSOFF);
            ERR_BUSOFF:  step_o = (node_in == ERR_ACTIVE);
            default:     step_o = 1'b0;
        endcase
    end

    assign node_q = state_q;

endmodule

// File: rtl/can_csr_flag_fsm.sv
module can_csr_flag_fsm
    import can_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    // a set in the same clock as a clear wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (set_i) state_d = FLAG_RAISED;
            FLAG_RAISED: if (!set_i && clr_i) state_d = FLAG_CLEAR;
            default:     state_d = FLAG_CLEAR;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_RAISED);

endmodule

// File: rtl/can_csr_activity.sv
module can_csr_activity
    import can_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic tx_msg_i,
    input  logic bus_msg_i,
    input  logic fault_frame_i,
    output logic tx_o,
    output logic rx_o
);

    act_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACT_IDLE;
        else        state_q <= state_d;
    end

    // every state re-evaluates the sampled activity
    always_comb begin
        state_d = ACT_IDLE;
        unique case (state_q)
            ACT_IDLE, ACT_RX, ACT_TX: begin
                if (halt_i || fault_frame_i) state_d = ACT_IDLE;
                else if (tx_msg_i)           state_d = ACT_TX;
                else if (bus_msg_i)          state_d = ACT_RX;
                else                         state_d = ACT_IDLE;
            end
            default: state_d = ACT_IDLE;
        endcase
    end

    always_comb begin
        tx_o = 1'b0;
        rx_o = 1'b0;
        unique case (state_q)
            ACT_IDLE: ;
            ACT_RX:   rx_o = 1'b1;
            ACT_TX: begin
                tx_o = 1'b1;
                rx_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/can_csr_ctrl.sv
module can_csr_ctrl
    import can_csr_pkg::*;
#(
    parameter logic HALT_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo_i,
    input  logic [LANE_W-1:0] wdata_lo_i,
    output logic              halt_o,
    output logic              oe_o,
    output logic              ie_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_o <= HALT_RST;
            oe_o   <= 1'b0;
            ie_o   <= 1'b0;
        end else if (wr_lo_i) begin
            halt_o <= wdata_lo_i[POS_HALT];
            oe_o   <= wdata_lo_i[POS_OE];
            ie_o   <= wdata_lo_i[POS_IE];
        end
    end

endmodule

// File: rtl/can_status_csr.sv
module can_status_csr
    import can_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_i,
    input  logic [LANES-1:0] bus_be_i,
    input  logic [CSR_W-1:0] bus_wdata_i,
    output logic [CSR_W-1:0] bus_rdata_o,
    input  logic [1:0]       node_state_i,
    input  logic             tx_msg_i,
    input  logic             bus_msg_i,
    input  logic             fault_frame_i,
    output logic             irq_o
);

    logic [LANES-1:0]  lane_wr;
    logic [LANE_W-1:0] lane_data [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g]   = bus_wr_i & bus_be_i[g];
        assign lane_data[g] = bus_wdata_i[g*LANE_W +: LANE_W];
    end

    node_e node_q;
    logic  step;
    logic  flag;
    logic  halt, oe, ie;
    logic  tx_act, rx_act;
    logic  flag_clr;

    assign flag_clr = lane_wr[1] & ~lane_data[1][POS_FLAG-LANE_W];

    can_csr_node_fsm u_node (
        .clk     (clk),
        .rst_n   (rst_n),
        .node_in (node_e'(node_state_i)),
        .node_q  (node_q),
        .step_o  (step)
    );

    can_csr_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (step),
        .clr_i  (flag_clr),
        .flag_o (flag)
    );

    can_csr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo_i    (lane_wr[0]),
        .wdata_lo_i (lane_data[0]),
        .halt_o     (halt),
        .oe_o       (oe),
        .ie_o       (ie)
    );

    can_csr_activity u_act (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_i        (halt),
        .tx_msg_i      (tx_msg_i),
        .bus_msg_i     (bus_msg_i),
        .fault_frame_i (fault_frame_i),
        .tx_o          (tx_act),
        .rx_o          (rx_act)
    );

    always_comb begin
        bus_rdata_o           = '0;
        bus_rdata_o[POS_TX]   = tx_act;
        bus_rdata_o[POS_RX]   = rx_act;
        bus_rdata_o[POS_FLAG] = flag;
        bus_rdata_o[POS_NS_H] = node_q[1];
        bus_rdata_o[POS_NS_L] = node_q[0];
        bus_rdata_o[POS_OE]   = oe;
        bus_rdata_o[POS_IE]   = ie;
        bus_rdata_o[POS_HALT] = halt;
    end

    assign irq_o = flag & ie;

endmodule

// File: rtl/can_status_csr_chk.sv
module can_status_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr_i,
    input logic [1:0]  bus_be_i,
    input logic [15:0] bus_wdata_i,
    input logic [15:0] bus_rdata_o,
    input logic [1:0]  node_state_i,
    input logic        tx_msg_i,
    input logic        bus_msg_i,
    input logic        fault_frame_i,
    input logic        irq_o
);

    logic qual;
    logic clr_wr;
    assign qual = (bus_rdata_o[9:8] == 2'b00 && node_state_i == 2'b01) ||
                  (bus_rdata_o[9:8] == 2'b01 && node_state_i == 2'b10) ||
                  (bus_rdata_o[9:8] == 2'b10 && node_state_i == 2'b11) ||
                  (bus_rdata_o[9:8] == 2'b11 && node_state_i == 2'b00);
    assign clr_wr = bus_wr_i && bus_be_i[1] && !bus_wdata_i[10];

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[13:11] == 3'b000 && bus_rdata_o[6:3] == 4'b0000 && !bus_rdata_o[1]);

    // R2
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[0] |=> !bus_rdata_o[15] && !bus_rdata_o[14]);

    // R3
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_frame_i |=> !bus_rdata_o[14]);

    // R4
    state_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bus_rdata_o[9:8] == $past(node_state_i));

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> bus_rdata_o[10]);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && !clr_wr) |=> bus_rdata_o[10] == $past(bus_rdata_o[10]));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && clr_wr) |=> !bus_rdata_o[10]);

    // R9
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (bus_rdata_o[10] && bus_rdata_o[2]));

    // R11
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_i || !bus_be_i[0]) |=> $stable(bus_rdata_o[7]) && $stable(bus_rdata_o[2]) && $stable(bus_rdata_o[0]));

endmodule

bind can_status_csr can_status_csr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr_i      (bus_wr_i),
    .bus_be_i      (bus_be_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .node_state_i  (node_state_i),
    .tx_msg_i      (tx_msg_i),
    .bus_msg_i     (bus_msg_i),
    .fault_frame_i (fault_frame_i),
    .irq_o         (irq_o)
);

// File: tb/test_can_status_csr.sv
module test_can_status_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [1:0]  bus_be_i = 2'b00;
    logic [15:0] bus_wdata_i = 16'h0000;
    logic [15:0] bus_rdata_o;
    logic [1:0]  node_state_i = 2'b00;
    logic        tx_msg_i = 1'b0;
    logic        bus_msg_i = 1'b0;
    logic        fault_frame_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    can_status_csr i_can_status_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr_i      (bus_wr_i),
        .bus_be_i      (bus_be_i),
        .bus_wdata_i   (bus_wdata_i),
        .bus_rdata_o   (bus_rdata_o),
        .node_state_i  (node_state_i),
        .tx_msg_i      (tx_msg_i),
        .bus_msg_i     (bus_msg_i),
        .fault_frame_i (fault_frame_i),
        .irq_o         (irq_o)
    );

    // fields: node(2) wr(1) be(2) wdata(16) tx,bus,fault(3) exp_rd(16) exp_irq(1)
    localparam int NV = 15;
    localparam logic [40:0] VEC [NV] = '{
        {2'b00, 1'b1, 2'b01, 16'h0084, 3'b000, 16'h0084, 1'b0}, // R10 load oe, ie, halt=0
        {2'b01, 1'b0, 2'b00, 16'h0000, 3'b110, 16'hC584, 1'b1}, // R5 00->01, R2 tx
        {2'b01, 1'b1, 2'b10, 16'hFFFF, 3'b010, 16'h4584, 1'b1}, // R7 write 1 ignored, R11, R3 rx only
        {2'b01, 1'b1, 2'b10, 16'h0000, 3'b111, 16'h0184, 1'b0}, // R7 clear, R3 fault
        {2'b00, 1'b0, 2'b00, 16'h0000, 3'b000, 16'h0084, 1'b0}, // R6 01->00
        {2'b10, 1'b0, 2'b00, 16'h0000, 3'b000, 16'h0284, 1'b0}, // R6 00->10
        {2'b11, 1'b0, 2'b00, 16'h0000, 3'b000, 16'h0784, 1'b1}, // R5 10->11
        {2'b00, 1'b1, 2'b10, 16'h0000, 3'b000, 16'h0484, 1'b1}, // R8 11->00 with clear
        {2'b00, 1'b1, 2'b01, 16'h0000, 3'b000, 16'h0400, 1'b0}, // R9 ie=0 masks
        {2'b00, 1'b1, 2'b01, 16'h0001, 3'b110, 16'hC401, 1'b0}, // R2 halt sampled old
        {2'b00, 1'b0, 2'b00, 16'h0000, 3'b110, 16'h0401, 1'b0}, // R2 halt blocks
        {2'b01, 1'b1, 2'b11, 16'h0004, 3'b000, 16'h0504, 1'b1}, // R8 00->01 with clear
        {2'b11, 1'b0, 2'b00, 16'h0000, 3'b000, 16'h0704, 1'b1}, // R6 01->11
        {2'b10, 1'b0, 2'b00, 16'h0000, 3'b000, 16'h0604, 1'b1}, // R6 11->10, R4
        {2'b10, 1'b1, 2'b00, 16'h0000, 3'b000, 16'h0604, 1'b1}  // R11 no byte enables
    };

    function automatic string req_of(int i);
        case (i)
            0:       return "R10";
            1, 6:    return "R5";
            2:       return "R7/R11";
            3:       return "R7/R3";
            4, 5:    return "R6";
            7, 11:   return "R8";
            8:       return "R9";
            9, 10:   return "R2";
            12, 13:  return "R6/R4";
            default: return "R11";
        endcase
    endfunction

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: irq=%b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value
        check16("R1", bus_rdata_o, 16'h0001);
        check1("R1", irq_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            node_state_i  = VEC[i][40:39];
            bus_wr_i      = VEC[i][38];
            bus_be_i      = VEC[i][37:36];
            bus_wdata_i   = VEC[i][35:20];
            tx_msg_i      = VEC[i][19];
            bus_msg_i     = VEC[i][18];
            fault_frame_i = VEC[i][17];
            @(negedge clk);
            check16(req_of(i), bus_rdata_o, VEC[i][16:1]);
            check1(req_of(i), irq_o, VEC[i][0]);
        end

        // R1 reset in mid-run restores the reset word
        bus_wr_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check16("R1", bus_rdata_o, 16'h0001);
        check1("R1", irq_o, 1'b0);
        rst_n = 1'b1;

        // R3 receive with halt set stays 0
        bus_msg_i = 1'b1;
        tx_msg_i  = 1'b0;
        fault_frame_i = 1'b0;
        node_state_i = 2'b00;
        @(negedge clk);
        check16("R3", bus_rdata_o, 16'h0001);

        // R10 writing only halt=0 then receive shows rx after one more clock
        bus_wr_i = 1'b1; bus_be_i = 2'b01; bus_wdata_i = 16'h0000;
        @(negedge clk);
        bus_wr_i = 1'b0;
        check16("R10", bus_rdata_o, 16'h0000);
        @(negedge clk);
        check16("R3", bus_rdata_o, 16'h4000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule